// File: doc/BRIEF.md
# Registered Five-Function ALU

This block is a 16-bit arithmetic and logic unit whose two operands and one result are each kept in a dedicated register. Both operand registers take their value from one shared data bus. A compute strobe, qualified by a 3-bit function code, stores the selected result in the result register. A separate output enable gates that result back onto the bus.

The unit performs addition, bitwise AND, OR and XOR, and two's-complement negation of the first operand. Carry and signed-overflow flags are registered with the result. They are updated by the same strobe, so they always describe the value currently held in the result register.

Top module: `reg_alu`

## Requirements
- R1: While rst_ni is low, and right after it rises, the operand registers, the result register, carry_o and ovf_o are all zero. A compute run straight after reset with code 000 therefore yields 0.
- R2: On a rising clock edge, operand X takes bus_i when ld_x_i is high and operand Y takes bus_i when ld_y_i is high. Each operand keeps its value when its own load input is low.
- R3: Code 000 (ADD) stores X + Y modulo 2^16. carry_o is set to the carry out of bit 15. ovf_o is set when X and Y have the same sign bit and the sum's sign bit differs from it.
- R4: Codes 001 (AND), 010 (OR) and 011 (XOR) store the bitwise result of X and Y, and they clear both carry_o and ovf_o.
- R5: Code 100 (NEG) stores the two's complement of X and ignores Y. It clears carry_o, and it sets ovf_o only when X is 0x8000, in which case the result is 0x8000.
- R6: Codes 101, 110 and 111 leave the result and both flags unchanged even when calc_i is high.
- R7: The result and the flags change only on a clock edge with calc_i high.
- R8: bus_o equals the result register while oe_i is high, and it is all zeros while oe_i is low.
- R9: A compute uses the operand values held before the edge. An operand loaded on the same edge is first used by the next compute.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_i | input | 16 | Shared data bus, read side |
| ld_x_i | input | 1 | Load operand X from bus_i |
| ld_y_i | input | 1 | Load operand Y from bus_i |
| calc_i | input | 1 | Compute strobe |
| func_i | input | 3 | Function code |
| oe_i | input | 1 | Drive the result onto bus_o |
| bus_o | output | 16 | Shared data bus, drive side; zero when not enabled |
| carry_o | output | 1 | Carry flag of the last compute |
| ovf_o | output | 1 | Signed overflow flag of the last compute |

## Verification
Addition is tried with four operand pairs. A plain sum has no carry or overflow. 0xFFFF+1 sets carry only, 0x7FFF+1 sets overflow only, and 0x8000+0x8000 sets both. Together these tell the two flags apart from each other and from the sum bits. The logic functions use the crossed patterns 0xF0F0 and 0x3C3C, so every truth-table row shows up and AND, OR and XOR give three different results; each of these runs follows an addition that left both flags set, so the flag clearing is visible. Negation is tried on 5, 0 and 0x8000, with a nonzero Y present each time to show that Y has no effect. A load and a compute on the same edge, calls with the strobe low, and the three unused codes show that the stored result holds whenever it should not change.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int unsigned FN_W = 3;

  typedef enum logic [FN_W-1:0] {
    FN_ADD = 3'b000,
    FN_AND = 3'b001,
    FN_OR  = 3'b010,
    FN_XOR = 3'b011,
    FN_NEG = 3'b100
  } alu_fn_e;

  typedef struct packed {
    logic carry;
    logic ovf;
  } alu_flags_t;

  function automatic logic fn_valid(input logic [FN_W-1:0] f);
    return f <= FN_NEG;
  endfunction

  function automatic logic fn_is_logic(input logic [FN_W-1:0] f);
    return (f == FN_AND) || (f == FN_OR) || (f == FN_XOR);
  endfunction
endpackage

// File: rtl/alu_operand_reg.sv
module alu_operand_reg #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (ld_i) q_o <= d_i;
  end

  AST_OPERAND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_i |=> $stable(q_o)); // R2
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic [FN_W-1:0]  func_i,
  output logic [WIDTH-1:0] res_o,
  output alu_flags_t       flags_o,
  output logic             valid_o
);
  localparam int unsigned MSB = WIDTH - 1;

  logic [WIDTH:0]   sum_ext;
  logic [WIDTH-1:0] neg_val;
  logic             add_ovf;
  logic             neg_ovf;

  assign sum_ext = {1'b0, x_i} + {1'b0, y_i};
  assign neg_val = ~x_i + {{(WIDTH-1){1'b0}}, 1'b1};
  // same operand signs, different result sign
  assign add_ovf = (x_i[MSB] == y_i[MSB]) && (sum_ext[MSB] != x_i[MSB]);
  // only the most negative value maps onto itself with the sign kept
  assign neg_ovf = x_i[MSB] && neg_val[MSB];

  assign valid_o = fn_valid(func_i);

  always_comb begin
    res_o   = '0;
    flags_o = '0;
    unique case (func_i)
      FN_ADD: begin
        res_o         = sum_ext[WIDTH-1:0];
        flags_o.carry = sum_ext[WIDTH];
        flags_o.ovf   = add_ovf;
      end
      FN_AND:  res_o = x_i & y_i;
      FN_OR:   res_o = x_i | y_i;
      FN_XOR:  res_o = x_i ^ y_i;
      FN_NEG: begin
        res_o       = neg_val;
        flags_o.ovf = neg_ovf;
      end
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/alu_result_reg.sv
module alu_result_reg
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             calc_i,
  input  logic             valid_i,
  input  logic [WIDTH-1:0] res_i,
  input  alu_flags_t       flags_i,
  output logic [WIDTH-1:0] z_o,
  output alu_flags_t       flags_o
);
  logic upd;
  assign upd = calc_i && valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      z_o     <= '0;
      flags_o <= '0;
    end else if (upd) begin
      z_o     <= res_i;
      flags_o <= flags_i;
    end
  end

  AST_NO_STROBE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !calc_i |=> $stable(z_o) && $stable(flags_o)); // R7
  AST_BAD_CODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    calc_i && !valid_i |=> $stable(z_o) && $stable(flags_o)); // R6
endmodule

// File: rtl/reg_alu.sv
module reg_alu
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] bus_i,
  input  logic             ld_x_i,
  input  logic             ld_y_i,
  input  logic             calc_i,
  input  logic [FN_W-1:0]  func_i,
  input  logic             oe_i,
  output logic [WIDTH-1:0] bus_o,
  output logic             carry_o,
  output logic             ovf_o
);
  localparam logic [WIDTH-1:0] MIN_NEG = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] x_q, y_q, z_q, res;
  alu_flags_t       flags_d, flags_q;
  logic             valid;

  alu_operand_reg #(.WIDTH(WIDTH)) u_x (
    .clk_i(clk_i), .rst_ni(rst_ni), .ld_i(ld_x_i), .d_i(bus_i), .q_o(x_q));

  alu_operand_reg #(.WIDTH(WIDTH)) u_y (
    .clk_i(clk_i), .rst_ni(rst_ni), .ld_i(ld_y_i), .d_i(bus_i), .q_o(y_q));

  alu_core #(.WIDTH(WIDTH)) u_core (
    .x_i(x_q), .y_i(y_q), .func_i(func_i),
    .res_o(res), .flags_o(flags_d), .valid_o(valid));

  alu_result_reg #(.WIDTH(WIDTH)) u_z (
    .clk_i(clk_i), .rst_ni(rst_ni), .calc_i(calc_i), .valid_i(valid),
    .res_i(res), .flags_i(flags_d), .z_o(z_q), .flags_o(flags_q));

  assign bus_o   = oe_i ? z_q : '0;
  assign carry_o = flags_q.carry;
  assign ovf_o   = flags_q.ovf;

  AST_ADD_SUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    calc_i && func_i == FN_ADD |=>
      {flags_q.carry, z_q} == {1'b0, $past(x_q)} + {1'b0, $past(y_q)}); // R3
  AST_LOGIC_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    calc_i && fn_is_logic(func_i) |=> !flags_q.carry && !flags_q.ovf); // R4
  AST_NEG_OVF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    calc_i && func_i == FN_NEG |=>
      (flags_q.ovf == ($past(x_q) == MIN_NEG)) && !flags_q.carry); // R5
  AST_NEG_VAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    calc_i && func_i == FN_NEG |=> z_q + $past(x_q) == '0); // R5
  AST_BUS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_i |-> $countones(bus_o) == 0); // R8
endmodule

// File: tb/sim_reg_alu.sv
module sim_reg_alu;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] bus_in;
  logic        ld_x, ld_y, calc, oe;
  logic [2:0]  func;
  logic [15:0] bus_out;
  logic        carry, ovf;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  reg_alu u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_i(bus_in), .ld_x_i(ld_x), .ld_y_i(ld_y),
    .calc_i(calc), .func_i(func), .oe_i(oe), .bus_o(bus_out),
    .carry_o(carry), .ovf_o(ovf));

  task automatic check(input string req, input logic [15:0] exp_z,
                       input logic exp_c, input logic exp_v);
    n_chk++;
    if (bus_out !== exp_z || carry !== exp_c || ovf !== exp_v) begin
      n_fail++;
      $display("FAIL %s: got z=%h c=%b v=%b, exp z=%h c=%b v=%b",
               req, bus_out, carry, ovf, exp_z, exp_c, exp_v);
    end
  endtask

  task automatic load(input logic to_x, input logic [15:0] v);
    @(negedge clk);
    bus_in = v; ld_x = to_x; ld_y = !to_x;
    @(negedge clk);
    ld_x = 1'b0; ld_y = 1'b0;
  endtask

  task automatic run(input logic [2:0] f);
    @(negedge clk);
    calc = 1'b1; func = f;
    @(negedge clk);
    calc = 1'b0;
  endtask

  task automatic t_reset;
    // R1: outputs cleared, then ADD of cleared operands is zero
    check("R1", 16'h0000, 1'b0, 1'b0);
    run(3'b000);
    check("R1", 16'h0000, 1'b0, 1'b0);
  endtask

  task automatic t_add;
    load(1, 16'h1234); load(0, 16'h4321); run(3'b000);
    check("R3", 16'h5555, 1'b0, 1'b0);
    load(1, 16'hFFFF); load(0, 16'h0001); run(3'b000);
    check("R3", 16'h0000, 1'b1, 1'b0);
    load(1, 16'h7FFF); run(3'b000);
    check("R3", 16'h8000, 1'b0, 1'b1);
    load(1, 16'h8000); load(0, 16'h8000); run(3'b000);
    check("R3", 16'h0000, 1'b1, 1'b1);
  endtask

  task automatic t_logic;
    // R4: each logic op follows an ADD with both flags set
    load(1, 16'hF0F0); load(0, 16'h3C3C); run(3'b001);
    check("R4", 16'h3030, 1'b0, 1'b0);
    load(1, 16'h8000); load(0, 16'h8000); run(3'b000);
    load(1, 16'hF0F0); load(0, 16'h3C3C); run(3'b010);
    check("R4", 16'hFCFC, 1'b0, 1'b0);
    load(1, 16'h8000); load(0, 16'h8000); run(3'b000);
    load(1, 16'hF0F0); load(0, 16'h3C3C); run(3'b011);
    check("R4", 16'hCCCC, 1'b0, 1'b0);
  endtask

  task automatic t_neg;
    load(0, 16'hABCD);
    load(1, 16'h0005); run(3'b100);
    check("R5", 16'hFFFB, 1'b0, 1'b0);
    load(1, 16'h0000); run(3'b100);
    check("R5", 16'h0000, 1'b0, 1'b0);
    load(1, 16'h8000); run(3'b100);
    check("R5", 16'h8000, 1'b0, 1'b1);
  endtask

  task automatic t_bad_codes;
    // R6: Z=0x8000, v=1 from last NEG must survive codes 5..7
    load(1, 16'h0001); load(0, 16'h0002);
    for (int c = 5; c < 8; c++) begin
      run(c[2:0]);
      check("R6", 16'h8000, 1'b0, 1'b1);
    end
  endtask

  task automatic t_hold;
    // R7: operands change, strobe stays low
    load(1, 16'h1111); load(0, 16'h2222);
    @(negedge clk); func = 3'b000;
    @(negedge clk);
    check("R7", 16'h8000, 1'b0, 1'b1);
    // R2: X kept 0x1111 when only Y was loaded
    run(3'b000);
    check("R2", 16'h3333, 1'b0, 1'b0);
  endtask

  task automatic t_oe;
    oe = 1'b0; #1;
    check("R8", 16'h0000, 1'b0, 1'b0);
    oe = 1'b1; #1;
    check("R8", 16'h3333, 1'b0, 1'b0);
  endtask

  task automatic t_same_edge;
    load(1, 16'h0001); load(0, 16'h0002);
    @(negedge clk);
    bus_in = 16'h000A; ld_x = 1'b1; calc = 1'b1; func = 3'b000;
    @(negedge clk);
    ld_x = 1'b0; calc = 1'b0;
    check("R9", 16'h0003, 1'b0, 1'b0);
    run(3'b000);
    check("R9", 16'h000C, 1'b0, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; bus_in = '0; ld_x = 0; ld_y = 0; calc = 0; func = '0; oe = 1'b1;
    #1;
    check("R1", 16'h0000, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_add();
    t_logic();
    t_neg();
    t_bad_codes();
    t_hold();
    t_oe();
    t_same_edge();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout, exp completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule